// File: doc/BRIEF.md
# I2C Byte-Level Bus Controller

This block is the controller side of a two-wire serial bus. It works through open-drain pads. It never drives a line high. For each of SCL and SDA it asserts an output-enable that pulls the line low, and it reads the line level back. A host sends it one command at a time. The command is a START condition, a STOP condition, a byte write or a byte read. The block then performs that command with correct bit timing on the bus.

For a write, the block returns the acknowledge level that the target gave in the ninth clock. For a read, it returns the received byte, and the host chooses whether the ninth clock acknowledges it. The bus timing comes from a quarter-period divider input. When the block releases SCL, it waits until it sees SCL high before it times the high phase. A slow target can therefore hold the clock low to stretch it. While the block sends a one, it also watches SDA. If SDA is low while SCL is high, another controller has won the bus. The block then releases both lines and reports lost arbitration.

A typical transfer is START, then a write of the address byte (7-bit address followed by a direction bit, 0 for write and 1 for read), then data writes or reads, then STOP.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, busy and done are 0 and both scl_oe and sda_oe are 0, so both lines are released.
- R2: A START command (opcode 00) releases SDA, then pulls SDA low while SCL is high, then pulls SCL low. When done is asserted, scl_oe is 1.
- R3: A STOP command (opcode 01) pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. When done is asserted, both enables are 0.
- R4: A WRITE command (opcode 10) shifts tx_byte out MSB first, one bit per SCL high pulse. SDA changes only while SCL is low, so no START or STOP condition appears inside the byte.
- R5: For a write, the block releases SDA for the ninth clock. ack_in is 1 when SDA was low in that clock and 0 when SDA was high.
- R6: A READ command (opcode 11) keeps SDA released for eight clocks. rx_byte holds the eight sampled levels, with the first one as the MSB.
- R7: For a read, the ninth clock has SDA pulled low when ack_out was 1 and released when ack_out was 0.
- R8: Each SCL high phase of a data bit lasts 2*max(div,1) clock cycles, counted from when SCL is first seen high. The bench allows one cycle less when the target releases SCL between clock edges.
- R9: While a target holds SCL low after the block has released it, the block stops its bit timing. Each stretched low lasts at least as long as the target holds it, and no data is lost.
- R10: If SDA is released to send a one but is read low while SCL is high, the block releases both lines at once. It asserts done with arb_lost set to 1 and produces no further SCL pulses.
- R11: A command is accepted when cmd_valid is 1 and busy is 0. busy is 1 from the next cycle until done. done is a one-cycle pulse. A cmd_valid while busy is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div | input | 16 | Quarter-period length in clock cycles (0 is treated as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 START, 01 STOP, 10 WRITE, 11 READ |
| tx_byte | input | 8 | Byte to send for WRITE |
| ack_out | input | 1 | For READ: 1 acknowledges the byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte received by READ, valid with done |
| ack_in | output | 1 | 1 when SDA was low in the ninth clock, valid with done |
| arb_lost | output | 1 | Arbitration lost, valid with done |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |

## Verification
A wrong phase state in the bit engine shows on the pads within one bit time. It appears as a START or STOP condition inside a byte, as a captured byte that differs from tx_byte, or as an SCL high pulse of the wrong length. A wrong bit counter in the byte sequencer shows as a ninth clock that is missing or doubled. That error is visible when done arrives, through ack_in, through rx_byte, or through the number of SCL pulses. A faulty arbitration or stretch path shows as SCL pulses that continue after the bus was lost, or as a low phase shorter than the one the target held.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    BK_START = 2'b00,
    BK_STOP  = 2'b01,
    BK_DATA  = 2'b10
  } bitkind_e;

  // Bus-level operation that a host command maps to
  function automatic bitkind_e kind_for(input op_e op);
    case (op)
      OP_START: return BK_START;
      OP_STOP:  return BK_STOP;
      default:  return BK_DATA;
    endcase
  endfunction

  // Level to present on SDA for one data slot (1 = released)
  function automatic logic slot_level(input op_e op, input logic msb,
                                      input logic ack_slot, input logic ack_req);
    if (op == OP_WRITE) return ack_slot ? 1'b1 : msb;
    if (op == OP_READ)  return ack_slot ? ~ack_req : 1'b1;
    return 1'b1;
  endfunction

endpackage

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic [DIV_W-1:0] div,
  output logic             qend
);

  // Last count value of one quarter; a zero divider behaves as one
  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  assign qend = count_en && !clear && (cnt_q == last_count(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear || qend) cnt_q <= '0;
    else if (count_en)      cnt_q <= cnt_q + 1'b1;
  end

  // R8
  quarter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && $stable(div)) |-> (cnt_q <= last_count(div)));

endmodule

// File: rtl/i2cm_bit_phy.sv
module i2cm_bit_phy
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  bitkind_e         kind,
  input  logic             tx_bit,
  input  logic             arb_en,
  input  logic [DIV_W-1:0] div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             rx_bit,
  output logic             lost
);

  logic       run_q;
  logic [1:0] phase_q;
  bitkind_e   kind_q;
  logic       arb_q;
  logic       qend;

  // Named internal events
  logic high_half;   // phases 2 and 3 belong to the SCL high phase
  logic high_wait;   // SCL released but not yet seen high (stretch)
  logic count_en;
  logic lost_now;

  assign high_half = run_q && phase_q[1];
  assign high_wait = high_half && !scl_in;
  assign count_en  = run_q && !high_wait;
  assign lost_now  = high_half && arb_q && (kind_q == BK_DATA) &&
                     scl_in && !sda_oe && !sda_in;

  i2cm_qtimer #(.DIV_W(DIV_W)) u_qtimer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .count_en (count_en),
    .div      (div),
    .qend     (qend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 2'd0;
      kind_q  <= BK_DATA;
      arb_q   <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      rx_bit  <= 1'b0;
      lost    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !run_q) begin
        run_q   <= 1'b1;
        phase_q <= 2'd0;
        kind_q  <= kind;
        arb_q   <= arb_en;
        lost    <= 1'b0;
        case (kind)
          BK_DATA: begin scl_oe <= 1'b1; sda_oe <= ~tx_bit; end
          BK_STOP: begin scl_oe <= 1'b1; sda_oe <= 1'b1;    end
          default: sda_oe <= 1'b0;
        endcase
      end else if (lost_now) begin
        run_q  <= 1'b0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        done   <= 1'b1;
        lost   <= 1'b1;
      end else if (run_q && qend) begin
        case (phase_q)
          2'd0: phase_q <= 2'd1;
          2'd1: begin
            phase_q <= 2'd2;
            scl_oe  <= 1'b0;
          end
          2'd2: begin
            phase_q <= 2'd3;
            if (kind_q == BK_DATA)  rx_bit <= sda_in;
            if (kind_q == BK_START) sda_oe <= 1'b1;
            if (kind_q == BK_STOP)  sda_oe <= 1'b0;
          end
          default: begin
            run_q <= 1'b0;
            done  <= 1'b1;
            if (kind_q != BK_STOP) scl_oe <= 1'b1;
          end
        endcase
      end
    end
  end

  // R4
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && kind_q == BK_DATA && sda_oe != $past(sda_oe)) |-> scl_oe);

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_wait |=> (run_q && $stable(phase_q)));

  // R10
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_now |=> (!scl_oe && !sda_oe && done && lost));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_out,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_in,
  output logic              arb_lost,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in
);

  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  op_e               op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] rxsh_q;
  logic              acko_q;
  logic              go_q;

  logic     accept;
  logic     ack_slot;
  logic     last_slot;
  bitkind_e phy_kind;
  logic     phy_tx;
  logic     phy_arb;
  logic     phy_done;
  logic     phy_rx;
  logic     phy_lost;

  assign accept    = cmd_valid && !busy;
  assign ack_slot  = (idx_q == ACK_IDX);
  assign last_slot = ack_slot || (op_q == OP_START) || (op_q == OP_STOP);
  assign phy_kind  = kind_for(op_q);
  assign phy_tx    = slot_level(op_q, sh_q[BYTE_W-1], ack_slot, acko_q);
  assign phy_arb   = (op_q == OP_WRITE) && !ack_slot;

  i2cm_bit_phy #(.DIV_W(DIV_W)) u_phy (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go_q),
    .kind   (phy_kind),
    .tx_bit (phy_tx),
    .arb_en (phy_arb),
    .div    (div),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .done   (phy_done),
    .rx_bit (phy_rx),
    .lost   (phy_lost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
      ack_in   <= 1'b0;
      arb_lost <= 1'b0;
      op_q     <= OP_START;
      idx_q    <= '0;
      sh_q     <= '0;
      rxsh_q   <= '0;
      acko_q   <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      go_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= op_e'(cmd_op);
        sh_q   <= tx_byte;
        acko_q <= ack_out;
        idx_q  <= '0;
        go_q   <= 1'b1;
      end else if (busy && phy_done) begin
        if (phy_lost || last_slot) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          arb_lost <= phy_lost;
          ack_in   <= ack_slot && !phy_lost && !phy_rx;
          rx_byte  <= rxsh_q;
        end else begin
          idx_q  <= idx_q + 1'b1;
          sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
          rxsh_q <= {rxsh_q[BYTE_W-2:0], phy_rx};
          go_q   <= 1'b1;
        end
      end
    end
  end

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arb_lost) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/tb_i2c_byte_engine.sv
module tb_i2c_byte_engine;

  localparam int CLK_P = 10;

  typedef struct {
    logic       ack;
    logic       chk_rx;
    logic [7:0] rx;
    logic       lost;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_r = 16'd3;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  tx_byte = 8'h00;
  logic        ack_out = 1'b0;
  logic        busy, done, ack_in, arb_lost, scl_oe, sda_oe;
  logic [7:0]  rx_byte;

  logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0, rival_low = 1'b0;
  wire  scl = !(scl_oe || tgt_scl_low);
  wire  sda = !(sda_oe || tgt_sda_low || rival_low);

  int checks = 0, fails = 0;
  exp_t sb_q[$];

  // Target model state
  int         mode = 0;          // 0 none, 1 write, 2 read
  logic       tgt_ack = 1'b0;
  logic [7:0] tgt_data = 8'h00;
  int         falls = 0, rises = 0;
  logic [7:0] cap = 8'h00;
  logic       nine_lvl = 1'b1;
  int         rd_drive_bad = 0;
  int         rival_at = -1;
  int         stretch_n = 0;
  int         n_start = 0, n_stop = 0;
  // Phase measurement
  bit         hchk_en = 1'b1, in_hi = 1'b0, lval = 1'b0;
  int         hcnt = 0, lcnt = 0, hi_bad = 0, hi_seen = 0, min_low = 1000000;

  i2c_byte_engine dut (
    .clk(clk), .rst_n(rst_n), .div(div_r), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tx_byte(tx_byte), .ack_out(ack_out), .busy(busy), .done(done), .rx_byte(rx_byte),
    .ack_in(ack_in), .arb_lost(arb_lost), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl), .sda_in(sda)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bus condition detection
  always @(negedge sda) if (scl === 1'b1) n_start++;
  always @(posedge sda) if (scl === 1'b1) n_stop++;

  // Target reactions on SCL falling edge
  always @(negedge scl) begin
    if (mode != 0) begin
      falls++;
      if (falls == rival_at) rival_low = 1'b1;
      if (mode == 1) begin
        if (falls == 8 && tgt_ack) tgt_sda_low = 1'b1;
        if (falls == 9) tgt_sda_low = 1'b0;
      end else if (mode == 2) begin
        if (falls < 8) tgt_sda_low = ~tgt_data[7-falls];
        if (falls == 8) tgt_sda_low = 1'b0;
      end
      lcnt = 0;
      lval = 1'b1;
    end
  end

  // Clock stretching by the target
  always @(negedge scl) begin
    if (stretch_n > 0 && mode != 0) begin
      tgt_scl_low = 1'b1;
      repeat (stretch_n) @(negedge clk);
      tgt_scl_low = 1'b0;
    end
  end

  // Capture on SCL rising edge
  always @(posedge scl) begin
    if (mode != 0) begin
      rises++;
      if (rises <= 8) begin
        cap = {cap[6:0], sda};
        if (mode == 2 && sda_oe) rd_drive_bad++;
      end
      if (rises == 9) nine_lvl = sda;
      in_hi = 1'b1;
      hcnt = 0;
    end
    if (lval) begin
      if (lcnt < min_low) min_low = lcnt;
      lval = 1'b0;
    end
  end

  // Phase-length sampler, away from the active edge
  always @(posedge clk) begin
    #1;
    if (in_hi) begin
      if (scl) hcnt++;
      else begin
        int q;
        q = (div_r == 0) ? 1 : int'(div_r);
        in_hi = 1'b0;
        if (hchk_en) begin
          hi_seen++;
          if (hcnt < 2*q - 1 || hcnt > 2*q) begin
            hi_bad++;
            $display("FAIL R8 high phase actual=%0d expected=%0d", hcnt, 2*q);
          end
        end
      end
    end
    if (lval && !scl) lcnt++;
  end

  // Scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(arb_lost == e.lost, {e.tag, " arb_lost"}, arb_lost, e.lost);
        chk(ack_in == e.ack, {e.tag, " ack_in"}, ack_in, e.ack);
        if (e.chk_rx) chk(rx_byte == e.rx, {e.tag, " rx_byte"}, rx_byte, e.rx);
      end
    end
  end

  // Driver: push expectation, present command, wait for completion
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] tb, input logic ao,
                         input int m, input logic e_ack, input logic e_chk_rx,
                         input logic [7:0] e_rx, input logic e_lost, input string tag);
    exp_t e;
    e.ack = e_ack; e.chk_rx = e_chk_rx; e.rx = e_rx; e.lost = e_lost; e.tag = tag;
    @(negedge clk);
    while (busy) @(negedge clk);
    mode = m; falls = 0; rises = 0; cap = 8'h00; nine_lvl = 1'b1;
    if (m == 2) tgt_sda_low = ~tgt_data[7];
    if (rival_at == 0) rival_low = 1'b1;
    sb_q.push_back(e);
    cmd_valid = 1'b1; cmd_op = op; tx_byte = tb; ack_out = ao;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_start = 0; n_stop = 0;
    // R1 reset state
    chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);

    // R2 START from idle
    run_cmd(2'b00, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R2 start");
    chk(n_start == 1, "R2 start condition seen", n_start, 1);
    chk(scl_oe == 1'b1, "R2 SCL held low after start", scl_oe, 1);

    // R4 R5 address byte (0x53, write) acknowledged
    tgt_ack = 1'b1;
    run_cmd(2'b10, 8'hA6, 1'b0, 1, 1'b1, 1'b0, 8'h00, 1'b0, "R5 write ack");
    chk(cap == 8'hA6, "R4 bits on bus MSB first", cap, 8'hA6);
    chk(n_start == 1 && n_stop == 0, "R4 no condition inside byte", n_start*16 + n_stop, 16);

    // R5 not-acknowledged byte
    tgt_ack = 1'b0;
    run_cmd(2'b10, 8'h3C, 1'b0, 1, 1'b0, 1'b0, 8'h00, 1'b0, "R5 write nack");
    chk(cap == 8'h3C, "R4 second pattern", cap, 8'h3C);

    // R6 R7 read with acknowledge
    tgt_data = 8'h96;
    run_cmd(2'b11, 8'h00, 1'b1, 2, 1'b1, 1'b1, 8'h96, 1'b0, "R6 read ack");
    chk(nine_lvl == 1'b0, "R7 ninth clock low for ack", nine_lvl, 0);
    // R6 R7 read with not-acknowledge
    tgt_data = 8'h5B;
    run_cmd(2'b11, 8'h00, 1'b0, 2, 1'b0, 1'b1, 8'h5B, 1'b0, "R6 read nack");
    chk(nine_lvl == 1'b1, "R7 ninth clock released for nack", nine_lvl, 1);
    chk(rd_drive_bad == 0, "R6 SDA released during read bits", rd_drive_bad, 0);

    // R11 command while busy is ignored
    fork
      run_cmd(2'b10, 8'hE1, 1'b0, 1, 1'b0, 1'b0, 8'h00, 1'b0, "R11 write");
      begin
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R11 busy during command", busy, 1);
        cmd_valid = 1'b1; cmd_op = 2'b01;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk(n_stop == 0, "R11 ignored stop left no trace", n_stop, 0);
    chk(cap == 8'hE1, "R11 write unaffected", cap, 8'hE1);

    // R3 STOP
    run_cmd(2'b01, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 stop");
    chk(n_stop == 1, "R3 stop condition seen", n_stop, 1);
    chk(!scl_oe && !sda_oe, "R3 lines released after stop", {scl_oe, sda_oe}, 0);

    // R9 clock stretching
    stretch_n = 20; min_low = 1000000;
    run_cmd(2'b00, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R9 start");
    tgt_ack = 1'b1;
    run_cmd(2'b10, 8'hC3, 1'b0, 1, 1'b1, 1'b0, 8'h00, 1'b0, "R9 write");
    chk(cap == 8'hC3, "R9 write byte under stretch", cap, 8'hC3);
    tgt_data = 8'h71;
    run_cmd(2'b11, 8'h00, 1'b1, 2, 1'b1, 1'b1, 8'h71, 1'b0, "R9 read");
    stretch_n = 0;
    chk(min_low >= 20, "R9 low phase covers stretch", min_low, 20);
    run_cmd(2'b01, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 stop2");

    // R8 fastest divider
    div_r = 16'd1;
    run_cmd(2'b00, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R8 start");
    run_cmd(2'b10, 8'h55, 1'b0, 1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 write");
    chk(cap == 8'h55, "R8 byte at div 1", cap, 8'h55);
    div_r = 16'd3;

    // R10 arbitration lost mid-byte (rival pulls SDA after the third falling edge)
    hchk_en = 1'b0; tgt_ack = 1'b0; rival_at = 3;
    run_cmd(2'b10, 8'hFF, 1'b0, 1, 1'b0, 1'b0, 8'h00, 1'b1, "R10 lost mid");
    repeat (30) @(negedge clk);
    chk(rises == 4, "R10 no SCL pulses after loss", rises, 4);
    chk(!scl_oe && !sda_oe, "R10 both lines released", {scl_oe, sda_oe}, 0);
    rival_low = 1'b0; rival_at = -1;
    @(negedge clk);

    // R10 arbitration lost on the first bit
    run_cmd(2'b00, 8'h00, 1'b0, 0, 1'b0, 1'b0, 8'h00, 1'b0, "R10 start");
    rival_at = 0;
    run_cmd(2'b10, 8'h80, 1'b0, 1, 1'b0, 1'b0, 8'h00, 1'b1, "R10 lost first");
    repeat (20) @(negedge clk);
    chk(rises == 1, "R10 single SCL pulse", rises, 1);
    rival_low = 1'b0; rival_at = -1;

    chk(hi_bad == 0 && hi_seen > 50, "R8 high phase lengths", hi_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule